// File: doc/BRIEF.md
# Raster Cursor Overlay

The block lays a small square cursor image over a stream of 24-bit RGB pixels heading for a display. The cursor image is a 32x32 grid of 16-bit entries held in a local memory that the host loads one entry per cycle through a write port. For every pixel on the stream the block compares the raster coordinate with the active cursor origin. Inside the cursor square it reads the matching entry, and from the entry it either lets the underlying pixel through, replaces it with an expanded 15-bit colour, or inverts it.

The host writes the cursor origin and the visibility bit into pending registers. Both move into the active registers only on a retrace-start pulse, so the cursor never tears or jumps in the middle of a frame. Each pixel comes out two clock cycles after it goes in, with its valid flag.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `out_valid` and `pix_out` are 0, the cursor is hidden and the active origin is (0,0).
- R2: A pixel presented with `pix_valid` high comes out on `pix_out` with `out_valid` high exactly two clock edges later. `out_valid` is low when no pixel was presented two edges earlier.
- R3: Bitmap write address `bm_waddr` selects row `bm_waddr[9:5]` and column `bm_waddr[4:0]`. A screen pixel at offset (dx,dy) from the origin uses the entry at row dy, column dx.
- R4: A pixel is covered only when ox <= x < ox+32 and oy <= y < oy+32, with (ox,oy) the active origin. Any pixel outside this square passes unchanged.
- R5: A covered pixel whose entry is 0x0000 passes unchanged.
- R6: An entry with bit 15 set is opaque. Bits 14:10, 9:5 and 4:0 are the red, green and blue fields. Each field f expands to the 8-bit value {f, f[4:2]}, and `pix_out` is {R,G,B} in bits 23:16, 15:8 and 7:0. For example, 0xFFFF gives 0xFFFFFF and 0x8000 gives 0x000000.
- R7: An entry of 0x7FFF inverts all 24 bits of the underlying pixel.
- R8: Any other entry with bit 15 clear behaves as transparent.
- R9: `pos_we` loads `pos_x_wdata` and `pos_y_wdata` into a pending origin. The active origin takes the pending value only on a cycle with `vretrace_start` high.
- R10: `ctl_we` loads `ctl_en_wdata` as the pending visibility bit. It becomes active only at a `vretrace_start`. A write in the same cycle as the pulse waits for the next pulse.
- R11: While the active visibility bit is 0, every pixel passes unchanged whatever the bitmap holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_we | input | 1 | Bitmap entry write strobe |
| bm_waddr | input | 10 | Bitmap entry address, row in the upper five bits |
| bm_wdata | input | 16 | Bitmap entry value |
| pos_we | input | 1 | Pending origin write strobe |
| pos_x_wdata | input | 12 | Origin column |
| pos_y_wdata | input | 12 | Origin row |
| ctl_we | input | 1 | Pending visibility write strobe |
| ctl_en_wdata | input | 1 | Visibility value |
| vretrace_start | input | 1 | One-cycle pulse at the start of vertical retrace |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 12 | Raster column of the input pixel |
| pix_y | input | 12 | Raster row of the input pixel |
| pix_in | input | 24 | Underlying RGB pixel |
| out_valid | output | 1 | Output pixel valid |
| pix_out | output | 24 | RGB pixel after the overlay |

## Verification
Each overlay result is due two rising edges after its pixel is driven: one edge registers the memory read and the coordinate match, and the next registers the mixed pixel. The bench drives on the falling edge, removes the valid flag one falling edge later and samples on the following falling edge, so every compare falls in the cycle the pixel lands. A register write needs one edge to reach the pending copy, and a retrace pulse needs one more edge to reach the active copy. The bench issues a pixel only after those edges have passed and compares it against a model whose active state changes at the same pulse.

// File: rtl/cur_pkg.sv
package cur_pkg;
   // what the mixer does with one covered pixel
   typedef enum logic [1:0] {
      MIX_PASS   = 2'd0,
      MIX_SOLID  = 2'd1,
      MIX_INVERT = 2'd2
   } mix_kind_t;

   function automatic mix_kind_t classify(input logic hit, input logic [15:0] ent);
      if (!hit)                 return MIX_PASS;
      else if (ent[15])         return MIX_SOLID;
      else if (&ent[14:0])      return MIX_INVERT;
      else                      return MIX_PASS;
   endfunction
endpackage

// File: rtl/cur_shadow_regs.sv
module cur_shadow_regs #(
   parameter int COORD_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pos_we,
   input  logic [COORD_W-1:0] pos_x_wdata,
   input  logic [COORD_W-1:0] pos_y_wdata,
   input  logic               ctl_we,
   input  logic               ctl_en_wdata,
   input  logic               vretrace_start,
   output logic [COORD_W-1:0] act_x,
   output logic [COORD_W-1:0] act_y,
   output logic               act_en
);
   logic [COORD_W-1:0] pend_x, pend_y;
   logic               pend_en;

   // host side copy
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_x  <= '0;
         pend_y  <= '0;
         pend_en <= 1'b0;
      end else begin
         if (pos_we) begin
            pend_x <= pos_x_wdata;
            pend_y <= pos_y_wdata;
         end
         if (ctl_we) pend_en <= ctl_en_wdata;
      end
   end

   // raster side copy, moved only at retrace; takes the pending value held before this edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_x  <= '0;
         act_y  <= '0;
         act_en <= 1'b0;
      end else if (vretrace_start) begin
         act_x  <= pend_x;
         act_y  <= pend_y;
         act_en <= pend_en;
      end
   end
endmodule

// File: rtl/cur_bitmap_ram.sv
module cur_bitmap_ram #(
   parameter int DEPTH = 1024,
   parameter int WIDTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/cur_pixel_mix.sv
module cur_pixel_mix
   import cur_pkg::*;
#(
   parameter int CUR_PX_W = 16,
   parameter int CH_W     = 8,
   localparam int FIELD_W = (CUR_PX_W - 1) / 3,
   localparam int OUT_W   = 3 * CH_W
) (
   input  logic                hit,
   input  logic [CUR_PX_W-1:0] cur_px,
   input  logic [OUT_W-1:0]    base_px,
   output logic [OUT_W-1:0]    mixed_px
);
   logic [OUT_W-1:0] solid_px;
   mix_kind_t        kind;

   // one expander per colour channel; variant picked by the width relation
   for (genvar ch = 0; ch < 3; ch++) begin : g_ch
      logic [FIELD_W-1:0] fld;
      assign fld = cur_px[ch*FIELD_W +: FIELD_W];
      if (CH_W == FIELD_W) begin : g_same
         assign solid_px[ch*CH_W +: CH_W] = fld;
      end else begin : g_repl
         assign solid_px[ch*CH_W +: CH_W] = {fld, fld[FIELD_W-1 -: (CH_W-FIELD_W)]};
      end
   end

   assign kind = classify(hit, cur_px);

   always_comb begin
      unique case (kind)
         MIX_SOLID:  mixed_px = solid_px;
         MIX_INVERT: mixed_px = ~base_px;
         default:    mixed_px = base_px;
      endcase
   end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
   parameter int COORD_W  = 12,
   parameter int CUR_DIM  = 32,
   parameter int CUR_PX_W = 16,
   parameter int CH_W     = 8,
   localparam int IDX_W   = $clog2(CUR_DIM),
   localparam int AW      = 2 * IDX_W,
   localparam int DEPTH   = CUR_DIM * CUR_DIM,
   localparam int OUT_W   = 3 * CH_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bm_we,
   input  logic [AW-1:0]       bm_waddr,
   input  logic [CUR_PX_W-1:0] bm_wdata,
   input  logic                pos_we,
   input  logic [COORD_W-1:0]  pos_x_wdata,
   input  logic [COORD_W-1:0]  pos_y_wdata,
   input  logic                ctl_we,
   input  logic                ctl_en_wdata,
   input  logic                vretrace_start,
   input  logic                pix_valid,
   input  logic [COORD_W-1:0]  pix_x,
   input  logic [COORD_W-1:0]  pix_y,
   input  logic [OUT_W-1:0]    pix_in,
   output logic                out_valid,
   output logic [OUT_W-1:0]    pix_out
);
   // elaboration checks on the parameter set
   if (CUR_DIM != (1 << IDX_W)) begin : g_bad_dim
      $error("CUR_DIM must be a power of two");
   end
   if (((CUR_PX_W - 1) % 3) != 0) begin : g_bad_px
      $error("CUR_PX_W must be one flag bit plus three equal fields");
   end
   if ((CH_W < (CUR_PX_W - 1) / 3) || (CH_W > 2 * ((CUR_PX_W - 1) / 3))) begin : g_bad_ch
      $error("CH_W must lie between one and two field widths");
   end
   if (COORD_W <= IDX_W) begin : g_bad_coord
      $error("COORD_W too small for the cursor size");
   end

   logic [COORD_W-1:0]  act_x, act_y;
   logic                act_en;

   cur_shadow_regs #(.COORD_W(COORD_W)) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .pos_we         (pos_we),
      .pos_x_wdata    (pos_x_wdata),
      .pos_y_wdata    (pos_y_wdata),
      .ctl_we         (ctl_we),
      .ctl_en_wdata   (ctl_en_wdata),
      .vretrace_start (vretrace_start),
      .act_x          (act_x),
      .act_y          (act_y),
      .act_en         (act_en)
   );

   // window match: a borrow out of the subtraction means left of / above the origin
   logic [COORD_W:0] dx, dy;
   logic             in_x, in_y, hit0;
   logic [AW-1:0]    rd_addr;

   assign dx      = {1'b0, pix_x} - {1'b0, act_x};
   assign dy      = {1'b0, pix_y} - {1'b0, act_y};
   assign in_x    = !dx[COORD_W] && (dx[COORD_W-1:IDX_W] == '0);
   assign in_y    = !dy[COORD_W] && (dy[COORD_W-1:IDX_W] == '0);
   assign hit0    = act_en && in_x && in_y;
   assign rd_addr = {dy[IDX_W-1:0], dx[IDX_W-1:0]};

   logic [CUR_PX_W-1:0] s1_cur;

   cur_bitmap_ram #(.DEPTH(DEPTH), .WIDTH(CUR_PX_W)) u_ram (
      .clk     (clk),
      .wr_en   (bm_we),
      .wr_addr (bm_waddr),
      .wr_data (bm_wdata),
      .rd_en   (pix_valid),
      .rd_addr (rd_addr),
      .rd_data (s1_cur)
   );

   // stage 1: alongside the memory read
   logic             s1_valid, s1_hit;
   logic [OUT_W-1:0] s1_pix;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hit   <= 1'b0;
         s1_pix   <= '0;
      end else begin
         s1_valid <= pix_valid;
         if (pix_valid) begin
            s1_hit <= hit0;
            s1_pix <= pix_in;
         end
      end
   end

   logic [OUT_W-1:0] mixed;

   cur_pixel_mix #(.CUR_PX_W(CUR_PX_W), .CH_W(CH_W)) u_mix (
      .hit      (s1_hit),
      .cur_px   (s1_cur),
      .base_px  (s1_pix),
      .mixed_px (mixed)
   );

   // stage 2: output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pix_out   <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) pix_out <= mixed;
      end
   end
endmodule

// File: rtl/cur_overlay_chk.sv
module cur_overlay_chk #(
   parameter int COORD_W  = 12,
   parameter int CUR_PX_W = 16,
   parameter int CH_W     = 8,
   localparam int FIELD_W = (CUR_PX_W - 1) / 3,
   localparam int OUT_W   = 3 * CH_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                vretrace_start,
   input logic [COORD_W-1:0]  act_x,
   input logic [COORD_W-1:0]  act_y,
   input logic                act_en,
   input logic                s1_valid,
   input logic                s1_hit,
   input logic [OUT_W-1:0]    s1_pix,
   input logic [CUR_PX_W-1:0] s1_cur,
   input logic                out_valid,
   input logic [OUT_W-1:0]    pix_out
);
   a_r9_origin_held: assert property (@(posedge clk) disable iff (!rst_n)
      !vretrace_start |=> ($stable(act_x) && $stable(act_y)));

   a_r10_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
      !vretrace_start |=> $stable(act_en));

   a_r2_valid_out: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !out_valid);

   a_r4_miss_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_hit) |=> (pix_out == $past(s1_pix)));

   a_r5_clear_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_hit && (s1_cur == '0)) |=> (pix_out == $past(s1_pix)));

   a_r7_invert: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_hit && !s1_cur[CUR_PX_W-1] && (&s1_cur[CUR_PX_W-2:0]))
      |=> (pix_out == ~$past(s1_pix)));

   a_r6_solid_red: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_hit && s1_cur[CUR_PX_W-1])
      |=> (pix_out[OUT_W-1 -: FIELD_W] == $past(s1_cur[CUR_PX_W-2 -: FIELD_W])));
endmodule

bind cursor_overlay cur_overlay_chk #(
   .COORD_W  (COORD_W),
   .CUR_PX_W (CUR_PX_W),
   .CH_W     (CH_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .vretrace_start (vretrace_start),
   .act_x          (act_x),
   .act_y          (act_y),
   .act_en         (act_en),
   .s1_valid       (s1_valid),
   .s1_hit         (s1_hit),
   .s1_pix         (s1_pix),
   .s1_cur         (s1_cur),
   .out_valid      (out_valid),
   .pix_out        (pix_out)
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bm_we = 1'b0;
   logic [9:0]  bm_waddr = '0;
   logic [15:0] bm_wdata = '0;
   logic        pos_we = 1'b0;
   logic [11:0] pos_x_wdata = '0, pos_y_wdata = '0;
   logic        ctl_we = 1'b0, ctl_en_wdata = 1'b0;
   logic        vretrace_start = 1'b0;
   logic        pix_valid = 1'b0;
   logic [11:0] pix_x = '0, pix_y = '0;
   logic [23:0] pix_in = '0;
   logic        out_valid;
   logic [23:0] pix_out;

   always #2 clk = ~clk;   // 250 MHz

   cursor_overlay u_cursor_overlay (
      .clk(clk), .rst_n(rst_n),
      .bm_we(bm_we), .bm_waddr(bm_waddr), .bm_wdata(bm_wdata),
      .pos_we(pos_we), .pos_x_wdata(pos_x_wdata), .pos_y_wdata(pos_y_wdata),
      .ctl_we(ctl_we), .ctl_en_wdata(ctl_en_wdata),
      .vretrace_start(vretrace_start),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
      .out_valid(out_valid), .pix_out(pix_out)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // bench model
   logic [15:0] bm [1024];
   int  p_x = 0, p_y = 0, a_x = 0, a_y = 0;
   bit  p_en = 0, a_en = 0;

   function automatic logic [7:0] ex5(input logic [4:0] f);
      return {f, f[4:2]};
   endfunction

   function automatic logic [23:0] model_px(input int x, input int y, input logic [23:0] p);
      int dx, dy;
      logic [15:0] c;
      if (!a_en) return p;
      dx = x - a_x;
      dy = y - a_y;
      if (dx < 0 || dx > 31 || dy < 0 || dy > 31) return p;
      c = bm[dy*32 + dx];
      if (c[15]) return {ex5(c[14:10]), ex5(c[9:5]), ex5(c[4:0])};
      if (c[14:0] == 15'h7fff) return ~p;
      return p;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_bm(input int addr, input logic [15:0] d);
      @(negedge clk);
      bm_we = 1'b1; bm_waddr = addr[9:0]; bm_wdata = d;
      bm[addr] = d;
      @(negedge clk);
      bm_we = 1'b0;
   endtask

   task automatic set_pos(input int x, input int y);
      @(negedge clk);
      pos_we = 1'b1; pos_x_wdata = x[11:0]; pos_y_wdata = y[11:0];
      @(negedge clk);
      pos_we = 1'b0;
      p_x = x; p_y = y;
   endtask

   task automatic set_en(input bit e);
      @(negedge clk);
      ctl_we = 1'b1; ctl_en_wdata = e;
      @(negedge clk);
      ctl_we = 1'b0;
      p_en = e;
   endtask

   task automatic retrace();
      @(negedge clk);
      vretrace_start = 1'b1;
      @(negedge clk);
      vretrace_start = 1'b0;
      a_x = p_x; a_y = p_y; a_en = p_en;
   endtask

   // drive one pixel, compare two edges later
   task automatic send_px(input int x, input int y, input logic [23:0] p, input string req);
      logic [23:0] e;
      e = model_px(x, y, p);
      @(negedge clk);
      pix_valid = 1'b1; pix_x = x[11:0]; pix_y = y[11:0]; pix_in = p;
      @(negedge clk);
      pix_valid = 1'b0; pix_x = $urandom; pix_y = $urandom; pix_in = $urandom;
      @(negedge clk);
      check(out_valid === 1'b1, {req, " valid"}, {31'd0, out_valid}, 32'd1);
      check(pix_out === e, req, {8'd0, pix_out}, {8'd0, e});
   endtask

   function automatic logic [15:0] rnd_entry();
      case ($urandom_range(0, 5))
         0: return 16'h0000;
         1: return 16'hffff;
         2: return 16'h8000;
         3: return 16'h7fff;
         4: return {1'b0, 15'($urandom)};
         default: return {1'b1, 15'($urandom)};
      endcase
   endfunction

   function automatic string kind_tag(input int x, input int y);
      int dx, dy;
      logic [15:0] c;
      dx = x - a_x; dy = y - a_y;
      if (!a_en) return "R11 random hidden";
      if (dx < 0 || dx > 31 || dy < 0 || dy > 31) return "R4 random outside";
      c = bm[dy*32 + dx];
      if (c == 16'h0000) return "R5 random clear";
      if (c[15]) return "R6 random solid";
      if (c[14:0] == 15'h7fff) return "R7 random invert";
      return "R8 random other";
   endfunction

   initial begin
      #(4 * 190000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      // R1: reset state
      check(out_valid === 1'b0, "R1 out_valid at reset", {31'd0, out_valid}, 32'd0);
      check(pix_out === 24'd0, "R1 pix_out at reset", {8'd0, pix_out}, 32'd0);
      rst_n = 1'b1;

      // R3: whole bitmap loaded by row/column address
      for (int i = 0; i < 1024; i++) wr_bm(i, rnd_entry());
      wr_bm(0, 16'h0000);
      wr_bm(1, 16'hffff);
      wr_bm(2, 16'h8000);
      wr_bm(3, 16'h7fff);
      wr_bm(4, 16'h1234);
      wr_bm(5, 16'hfc1f);
      wr_bm(32, 16'h83e0);
      wr_bm(31*32 + 31, 16'hffff);

      // R1/R11: hidden after reset, origin still at zero
      send_px(1, 0, 24'h123456, "R1 hidden after reset");
      set_pos(100, 50);
      set_en(1'b1);
      // R9/R10: not applied before retrace
      send_px(101, 50, 24'h00aa55, "R10 pending before retrace");
      retrace();

      send_px(100, 50, 24'h3c5a7e, "R5 clear entry");
      send_px(101, 50, 24'h102030, "R6 white");
      check(pix_out === 24'hffffff, "R6 white value", {8'd0, pix_out}, 32'hffffff);
      send_px(102, 50, 24'h102030, "R6 black");
      send_px(105, 50, 24'h000000, "R6 expanded magenta");
      check(pix_out === 24'hff00ff, "R6 magenta value", {8'd0, pix_out}, 32'hff00ff);
      send_px(103, 50, 24'h0f0f0f, "R7 invert");
      check(pix_out === 24'hf0f0f0, "R7 invert value", {8'd0, pix_out}, 32'hf0f0f0);
      send_px(104, 50, 24'h445566, "R8 other clear-flag entry");
      send_px(100, 51, 24'h000000, "R3 row one column zero");
      check(pix_out === 24'h00ff00, "R3 row select", {8'd0, pix_out}, 32'h00ff00);
      send_px(131, 81, 24'h010101, "R4 last corner inside");
      send_px(132, 81, 24'h010101, "R4 right of square");
      send_px(131, 82, 24'h010101, "R4 below square");
      send_px(99, 50, 24'h010101, "R4 left of square");
      send_px(100, 49, 24'h010101, "R4 above square");

      // R2: no output without input
      @(negedge clk);
      check(out_valid === 1'b0, "R2 idle valid low", {31'd0, out_valid}, 32'd0);

      // R9: move takes effect only at retrace
      set_pos(200, 300);
      send_px(101, 50, 24'h777777, "R9 old origin still active");
      retrace();
      send_px(201, 300, 24'h777777, "R9 new origin");
      send_px(101, 50, 24'h777777, "R9 old origin released");

      // R10: visibility write in the retrace cycle waits a frame
      @(negedge clk);
      ctl_we = 1'b1; ctl_en_wdata = 1'b0; vretrace_start = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0; vretrace_start = 1'b0;
      a_x = p_x; a_y = p_y; a_en = p_en; p_en = 1'b0;
      send_px(201, 300, 24'h222222, "R10 same-cycle write deferred");
      retrace();
      send_px(201, 300, 24'h222222, "R11 hidden passes");

      // random phase
      for (int blk = 0; blk < 12; blk++) begin
         for (int k = 0; k < 8; k++) wr_bm($urandom_range(0, 1023), rnd_entry());
         set_pos($urandom_range(0, 4000), $urandom_range(0, 4000));
         set_en(($urandom_range(0, 4) != 0));
         retrace();
         for (int k = 0; k < 120; k++) begin
            int x, y;
            x = a_x + $urandom_range(0, 48) - 8;
            y = a_y + $urandom_range(0, 48) - 8;
            if (x < 0 || x > 4095) x = a_x;
            if (y < 0 || y > 4095) y = a_y;
            send_px(x, y, 24'($urandom), kind_tag(x, y));
         end
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule